// File: doc/BRIEF.md
# Dual-Bank Image Validator and Selector

This block decides at start-up which of two stored configuration images to trust. The images sit in two equal halves of a byte-wide memory that the block reads through a synchronous port with one cycle of read latency. Every start pulse begins one full pass over both halves. In each half the block reads a 24-byte header and the payload behind it. It checks a fixed marker byte, a short 8-bit end-around-carry sum over part of the header, and a 32-bit dual-accumulator sum taken modulo 65521 over the generation field and everything after it.

When both halves have been read, the block reports a valid flag and a generation number for each half. It also reports which half holds the newest valid image, and it raises an error flag if neither half is usable. The results are held, with `done` high, until the next accepted start. A system controller pulses `start` after reset, waits for `done`, and then loads its settings from the chosen half.

Header layout, per half, with offsets relative to the start of the half. Multi-byte fields are most significant byte first.
- Byte 0: marker, which must equal 0xC3.
- Byte 1: header sum.
- Bytes 2–3: length.
- Bytes 4–15: name.
- Bytes 16–19: payload sum.
- Bytes 20–23: generation.

Top module: `dual_image_picker`

## Requirements
- R1: While reset is held and on the first cycle after it, `done`, `no_image`, both bits of `bank_valid` and `rd_en` are 0.
- R2: An accepted start makes the block read every address from 0 to 2·BANK_BYTES−1 in ascending order, one address per cycle with `rd_en` high. The first half occupies addresses 0 to BANK_BYTES−1 and the second half follows it. `rd_en` is high for exactly 2·BANK_BYTES cycles per scan.
- R3: A half whose byte 0 is not 0xC3 is reported invalid.
- R4: A half is reported invalid unless byte 1 equals F(0xC3 + the sum of bytes 2 to 15). F(x) repeatedly replaces x by (x & 0xFF) + (x >> 8) until x ≤ 0xFF.
- R5: A half is reported invalid unless bytes 16–19 equal {high, low}. The sums start with low = 1 and high = 0. For each byte from offset 20 to the end of the half, in order, low is set to low + byte and then high is set to high + low. Both sums are reduced modulo 65521.
- R6: For a valid half, `gen0` or `gen1` reports bytes 20–23 as an unsigned 32-bit value. For an invalid half it reports 0.
- R7: If both halves are valid, `sel_bank` is 0 only when the generation of the first half is strictly greater than that of the second; a tie selects 1. If exactly one half is valid, `sel_bank` names that half.
- R8: If neither half is valid, `no_image` is 1 and `sel_bank` is 1. Otherwise `no_image` is 0.
- R9: An accepted start clears `done` on the same edge. `done` rises on the 2·BANK_BYTES+2-th rising edge after the accepting edge. All results then hold until the next accepted start.
- R10: A start pulse that arrives while a scan is in progress is ignored: the scan and its completion timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a scan when the block is not already scanning |
| rd_en | output | 1 | Read request to the memory |
| rd_addr | output | ADDR_W | Byte address of the read request |
| rd_data | input | 8 | Read data, valid in the cycle after the request edge |
| done | output | 1 | Scan finished, results valid and held |
| bank_valid | output | 2 | Bit b is 1 when half b passed all three checks |
| gen0 | output | 32 | Generation of the first half (0 if invalid) |
| gen1 | output | 32 | Generation of the second half (0 if invalid) |
| sel_bank | output | 1 | Selected half |
| no_image | output | 1 | Neither half is valid |

## Verification
A read issued at an edge returns its byte, which is consumed one edge later. The verdict on a half is registered one edge after that half's last byte, so every result becomes visible together with `done`, exactly 2·BANK_BYTES+2 edges after the accepting edge. The bench counts edges from the accepting edge and requires `done` on that exact count, neither earlier nor later. It compares all results at the falling edge that follows, then samples them again a few cycles later to confirm they hold. A monitor compares each request address with a running expected count, and a start injected during a scan must leave both the address stream and the edge count unchanged.

// File: rtl/pick_pkg.sv
// Package: shared constants for the dual-bank image validator.
// Holds the header field offsets, the marker byte, the accumulator widths
// and the end-around-carry fold used by the header check.
package pick_pkg;

    localparam logic [7:0] MARK_BYTE   = 8'hC3;

    localparam int OFS_MARK    = 0;
    localparam int OFS_HSUM    = 1;
    localparam int OFS_HSPAN_A = 2;
    localparam int OFS_HSPAN_B = 15;
    localparam int OFS_WSUM_A  = 16;
    localparam int OFS_WSUM_B  = 19;
    localparam int OFS_GEN_A   = 20;
    localparam int OFS_GEN_B   = 23;
    localparam int HDR_BYTES   = 24;

    // Header span is 14 bytes plus the marker seed: 15*255 < 4096.
    localparam int HSUM_W = 12;
    // Per-byte modular reduction keeps both sums below 2^17.
    localparam int ACC_W  = 17;
    localparam logic [ACC_W-1:0] WMOD = 17'd65521;
    localparam int GEN_W  = 32;

    typedef logic [GEN_W-1:0] gen_t;

    // Two end-around-carry folds bring any 12-bit value into 8 bits.
    function automatic logic [7:0] fold8(input logic [HSUM_W-1:0] s);
        logic [HSUM_W-1:0] t;
        t = s;
        for (int i = 0; i < 2; i++) begin
            t = {{(HSUM_W-8){1'b0}}, t[7:0]} + (t >> 8);
        end
        return t[7:0];
    endfunction

endpackage

// File: rtl/pick_scan_seq.sv
// Module: pick_scan_seq
// Drives the read port through both halves, one address per cycle, and tags
// each returning byte with its offset and half. Assumes one cycle of read
// latency. Raises bank_end for one cycle after the last byte of a half.
module pick_scan_seq #(
    parameter int BANK_BYTES = 8192,
    parameter int OFF_W      = 13,
    parameter int ADDR_W     = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              go,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              byte_vld,
    output logic [OFF_W-1:0]  byte_off,
    output logic              byte_bank,
    output logic              bank_end,
    output logic              end_bank
);
    localparam logic [OFF_W-1:0]  LAST_OFF = OFF_W'(BANK_BYTES - 1);
    localparam logic [ADDR_W-1:0] HALF     = ADDR_W'(BANK_BYTES);

    logic             active_q;
    logic             issue_q;
    logic             bank_q;
    logic [OFF_W-1:0] off_q;

    assign go      = start && !active_q;
    assign rd_en   = issue_q;
    assign rd_addr = bank_q ? (HALF + ADDR_W'(off_q)) : ADDR_W'(off_q);

    // Issue counter: walks offsets of half 0 then half 1, then stops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            issue_q  <= 1'b0;
            bank_q   <= 1'b0;
            off_q    <= '0;
        end else if (go) begin
            active_q <= 1'b1;
            issue_q  <= 1'b1;
            bank_q   <= 1'b0;
            off_q    <= '0;
        end else begin
            if (issue_q) begin
                if (off_q == LAST_OFF) begin
                    off_q  <= '0;
                    bank_q <= ~bank_q;
                    if (bank_q) issue_q <= 1'b0;
                end else begin
                    off_q <= off_q + 1'b1;
                end
            end
            if (bank_end && end_bank) active_q <= 1'b0;
        end
    end

    // Tag pipeline: aligns offset and half with the byte returning next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_vld  <= 1'b0;
            byte_off  <= '0;
            byte_bank <= 1'b0;
            bank_end  <= 1'b0;
            end_bank  <= 1'b0;
        end else begin
            byte_vld  <= issue_q;
            byte_off  <= off_q;
            byte_bank <= bank_q;
            bank_end  <= byte_vld && (byte_off == LAST_OFF);
            end_bank  <= byte_bank;
        end
    end

    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && $past(rd_en) |-> rd_addr == $past(rd_addr) + ADDR_W'(1));

    a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> rd_addr <= ADDR_W'(2 * BANK_BYTES - 1));

    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start && active_q |=> !(rd_en && rd_addr == '0));

endmodule

// File: rtl/pick_hdr_check.sv
// Module: pick_hdr_check
// Captures the marker and stored header sum of one half and accumulates the
// header span, seeded with the marker constant. Assumes bytes arrive in
// offset order starting at 0; results are read while the half's last byte
// is one cycle old.
module pick_hdr_check #(
    parameter int OFF_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic [OFF_W-1:0] byte_off,
    input  logic [7:0]       byte_in,
    output logic             mark_ok,
    output logic             hsum_ok
);
    import pick_pkg::*;

    logic [7:0]        mark_q;
    logic [7:0]        want_q;
    logic [HSUM_W-1:0] acc_q;
    logic              in_span;

    assign in_span = (byte_off >= OFF_W'(OFS_HSPAN_A)) && (byte_off <= OFF_W'(OFS_HSPAN_B));

    // Header capture and span accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= '0;
            want_q <= '0;
            acc_q  <= '0;
        end else if (byte_vld) begin
            if (byte_off == OFF_W'(OFS_MARK)) begin
                mark_q <= byte_in;
                acc_q  <= HSUM_W'(MARK_BYTE);
            end else if (byte_off == OFF_W'(OFS_HSUM)) begin
                want_q <= byte_in;
            end else if (in_span) begin
                acc_q <= acc_q + HSUM_W'(byte_in);
            end
        end
    end

    assign mark_ok = (mark_q == MARK_BYTE);
    assign hsum_ok = (fold8(acc_q) == want_q);

    a_r4_span_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= HSUM_W'(32'd255 * (OFS_HSPAN_B - OFS_HSPAN_A + 2)));

endmodule

// File: rtl/pick_wide_check.sv
// Module: pick_wide_check
// Computes the mod-65521 dual-accumulator sum over the generation field and
// the rest of a half, reducing after every byte. Captures the stored 32-bit
// sum and the generation, both most significant byte first.
module pick_wide_check #(
    parameter int OFF_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic [OFF_W-1:0] byte_off,
    input  logic [7:0]       byte_in,
    output logic             wsum_ok,
    output pick_pkg::gen_t   gen_val
);
    import pick_pkg::*;

    logic [ACC_W-1:0] lo_q, hi_q;
    logic [ACC_W-1:0] lo_sum, lo_nx, hi_sum, hi_nx;
    logic [31:0]      want_q;
    gen_t             gen_q;
    logic             in_wsum, in_gen, in_body;

    assign in_wsum = (byte_off >= OFF_W'(OFS_WSUM_A)) && (byte_off <= OFF_W'(OFS_WSUM_B));
    assign in_gen  = (byte_off >= OFF_W'(OFS_GEN_A))  && (byte_off <= OFF_W'(OFS_GEN_B));
    assign in_body = (byte_off >= OFF_W'(OFS_GEN_A));

    // One-step modular update of both sums.
    always_comb begin
        lo_sum = lo_q + ACC_W'(byte_in);
        lo_nx  = (lo_sum >= WMOD) ? (lo_sum - WMOD) : lo_sum;
        hi_sum = hi_q + lo_nx;
        hi_nx  = (hi_sum >= WMOD) ? (hi_sum - WMOD) : hi_sum;
    end

    // Sum registers, stored-sum and generation capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= ACC_W'(1);
            hi_q   <= '0;
            want_q <= '0;
            gen_q  <= '0;
        end else if (byte_vld) begin
            if (byte_off == OFF_W'(OFS_MARK)) begin
                lo_q <= ACC_W'(1);
                hi_q <= '0;
            end
            if (in_wsum) want_q <= {want_q[23:0], byte_in};
            if (in_gen)  gen_q  <= {gen_q[GEN_W-9:0], byte_in};
            if (in_body) begin
                lo_q <= lo_nx;
                hi_q <= hi_nx;
            end
        end
    end

    assign wsum_ok = ({hi_q[15:0], lo_q[15:0]} == want_q);
    assign gen_val = gen_q;

    a_r5_sums_reduced: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_q < WMOD) && (hi_q < WMOD));

endmodule

// File: rtl/dual_image_picker.sv
// Module: dual_image_picker (top)
// Scans both halves of a byte-wide memory once per accepted start, judges
// each half by marker, header sum and payload sum, and picks the valid half
// with the larger generation (a tie picks half 1). Assumes BANK_BYTES >= 24
// and a read port with one cycle of latency.
module dual_image_picker #(
    parameter  int BANK_BYTES = 8192,
    localparam int ADDR_W     = $clog2(2 * BANK_BYTES),
    localparam int OFF_W      = $clog2(BANK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              done,
    output logic [1:0]        bank_valid,
    output logic [31:0]       gen0,
    output logic [31:0]       gen1,
    output logic              sel_bank,
    output logic              no_image
);
    import pick_pkg::*;

    logic             go;
    logic             byte_vld, byte_bank, bank_end, end_bank;
    logic [OFF_W-1:0] byte_off;
    logic             mark_ok, hsum_ok, wsum_ok;
    gen_t             gen_val;
    logic             cur_ok;
    gen_t             cur_gen;
    logic             pick1;

    logic             done_q, sel_q, none_q;
    logic [1:0]       valid_q;
    gen_t             gen0_q, gen1_q;

    pick_scan_seq #(
        .BANK_BYTES (BANK_BYTES),
        .OFF_W      (OFF_W),
        .ADDR_W     (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .go        (go),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .byte_vld  (byte_vld),
        .byte_off  (byte_off),
        .byte_bank (byte_bank),
        .bank_end  (bank_end),
        .end_bank  (end_bank)
    );

    pick_hdr_check #(.OFF_W(OFF_W)) u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .byte_off (byte_off),
        .byte_in  (rd_data),
        .mark_ok  (mark_ok),
        .hsum_ok  (hsum_ok)
    );

    pick_wide_check #(.OFF_W(OFF_W)) u_wide (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .byte_off (byte_off),
        .byte_in  (rd_data),
        .wsum_ok  (wsum_ok),
        .gen_val  (gen_val)
    );

    // Verdict for the half that just ended, and the arbitration against half 0.
    always_comb begin
        cur_ok  = mark_ok && hsum_ok && wsum_ok;
        cur_gen = cur_ok ? gen_val : '0;
        pick1   = !(valid_q[0] && (!cur_ok || (gen0_q > cur_gen)));
    end

    // Result registers: cleared by an accepted start, written at each half's end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            sel_q   <= 1'b0;
            none_q  <= 1'b0;
            valid_q <= '0;
            gen0_q  <= '0;
            gen1_q  <= '0;
        end else if (go) begin
            done_q  <= 1'b0;
            sel_q   <= 1'b0;
            none_q  <= 1'b0;
            valid_q <= '0;
        end else if (bank_end) begin
            if (!end_bank) begin
                valid_q[0] <= cur_ok;
                gen0_q     <= cur_gen;
            end else begin
                valid_q[1] <= cur_ok;
                gen1_q     <= cur_gen;
                sel_q      <= pick1;
                none_q     <= !valid_q[0] && !cur_ok;
                done_q     <= 1'b1;
            end
        end
    end

    assign done       = done_q;
    assign bank_valid = valid_q;
    assign gen0       = gen0_q;
    assign gen1       = gen1_q;
    assign sel_bank   = sel_q;
    assign no_image   = none_q;

    a_r7_sel_names_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done && !no_image |-> (sel_bank ? bank_valid[1] : bank_valid[0]));

    a_r7_newer_wins: assert property (@(posedge clk) disable iff (!rst_n)
        done && (bank_valid == 2'b11) |-> (sel_bank == !(gen0 > gen1)));

    a_r8_none_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done && no_image |-> (bank_valid == 2'b00) && sel_bank);

    a_r6_invalid_gen_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bank_valid[0] || gen0 == '0) && (bank_valid[1] || gen1 == '0));

    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(sel_bank) && $stable(bank_valid));

endmodule

// File: tb/dual_image_picker_bench.sv
`timescale 1ns/1ps
module dual_image_picker_bench;
    localparam int N  = 512;
    localparam int AW = $clog2(2 * N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          done;
    logic [1:0]    bank_valid;
    logic [31:0]   gen0, gen1;
    logic          sel_bank, no_image;

    int n_cmp = 0;
    int n_bad = 0;
    int rd_total = 0;
    int rd_bad = 0;

    logic [7:0] mem [0:2*N-1];

    always #10 clk = ~clk;

    dual_image_picker #(.BANK_BYTES(N)) u_dual_image_picker (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .done(done), .bank_valid(bank_valid), .gen0(gen0),
        .gen1(gen1), .sel_bank(sel_bank), .no_image(no_image)
    );

    // Memory model with one cycle of read latency.
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    // Address monitor for R2: each request must follow a running count.
    always @(posedge clk) begin
        if (rd_en) begin
            if (int'(rd_addr) != (rd_total % (2 * N))) rd_bad++;
            rd_total++;
        end
    end

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic build_bank(input int b, input logic [31:0] g, input int seed, input bit ffill);
        int base;
        longint lo, hi, hs;
        base = b * N;
        for (int i = 0; i < N; i++)
            mem[base+i] = ffill ? 8'hFF : 8'(i * 37 + seed * 11 + b * 5 + (i >> 3));
        mem[base+0]  = 8'hC3;
        mem[base+2]  = 8'(N >> 8);
        mem[base+3]  = 8'(N);
        mem[base+20] = g[31:24];
        mem[base+21] = g[23:16];
        mem[base+22] = g[15:8];
        mem[base+23] = g[7:0];
        lo = 1; hi = 0;
        for (int i = 20; i < N; i++) begin
            lo = lo + longint'(mem[base+i]);
            hi = hi + lo;
        end
        lo = lo % 65521;
        hi = hi % 65521;
        mem[base+16] = 8'(hi >> 8);
        mem[base+17] = 8'(hi);
        mem[base+18] = 8'(lo >> 8);
        mem[base+19] = 8'(lo);
        hs = 'hC3;
        for (int i = 2; i <= 15; i++) hs = hs + longint'(mem[base+i]);
        while (hs > 255) hs = (hs & 255) + (hs >> 8);
        mem[base+1] = 8'(hs);
    endtask

    function automatic int kind_off(input int c);
        case (c)
            1: return 0;
            2: return 1;
            3: return 2;
            4: return 9;
            5: return N - 1;
            6: return 17;
            default: return 23;
        endcase
    endfunction

    function automatic string kind_req(input int c);
        if (c == 1) return "R3";
        if (c <= 4) return "R4";
        return "R5";
    endfunction

    task automatic run_check(input bit v0, input bit v1, input logic [31:0] g0, input logic [31:0] g1,
                             input string rq0, input string rq1, input bit poke);
        int n, rd0, bad0;
        logic [31:0] eg0, eg1;
        bit esel, eerr, sel_seen;
        eg0  = v0 ? g0 : 32'd0;
        eg1  = v1 ? g1 : 32'd0;
        esel = !(v0 && (!v1 || (eg0 > eg1)));
        eerr = !v0 && !v1;
        rd0  = rd_total;
        bad0 = rd_bad;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check_eq("R9", "done cleared by start", longint'(done), 0);
        n = 0;
        while (n < 4000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = poke && (n == 100);
            if (done) break;
        end
        start = 1'b0;
        check_eq(poke ? "R10" : "R9", "edges to done", n, 2 * N + 2);
        check_eq("R2", "read count", rd_total - rd0, 2 * N);
        check_eq("R2", "address mismatches", rd_bad - bad0, 0);
        check_eq(rq0, "bank_valid[0]", longint'(bank_valid[0]), longint'(v0));
        check_eq(rq1, "bank_valid[1]", longint'(bank_valid[1]), longint'(v1));
        check_eq("R6", "gen0", longint'(gen0), longint'(eg0));
        check_eq("R6", "gen1", longint'(gen1), longint'(eg1));
        check_eq("R7", "sel_bank", longint'(sel_bank), longint'(esel));
        check_eq("R8", "no_image", longint'(no_image), longint'(eerr));
        sel_seen = sel_bank;
        repeat (4) @(negedge clk);
        check_eq("R9", "done held", longint'(done), 1);
        check_eq("R9", "sel held", longint'(sel_bank), longint'(sel_seen));
    endtask

    logic [31:0] pg0 [0:8];
    logic [31:0] pg1 [0:8];

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        pg0[0] = 32'd5;          pg1[0] = 32'd3;
        pg0[1] = 32'd3;          pg1[1] = 32'd5;
        pg0[2] = 32'd7;          pg1[2] = 32'd7;
        pg0[3] = 32'd0;          pg1[3] = 32'd0;
        pg0[4] = 32'h0100_0000;  pg1[4] = 32'h0000_00FF;
        pg0[5] = 32'h0000_00FF;  pg1[5] = 32'h0100_0000;
        pg0[6] = 32'hFFFF_FFFF;  pg1[6] = 32'd0;
        pg0[7] = 32'd0;          pg1[7] = 32'hFFFF_FFFF;
        pg0[8] = 32'h8000_0000;  pg1[8] = 32'h7FFF_FFFF;

        // R1: reset state.
        repeat (4) @(negedge clk);
        check_eq("R1", "done in reset", longint'(done), 0);
        check_eq("R1", "no_image in reset", longint'(no_image), 0);
        check_eq("R1", "bank_valid in reset", longint'(bank_valid), 0);
        check_eq("R1", "rd_en in reset", longint'(rd_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "done after reset", longint'(done), 0);
        check_eq("R1", "rd_en after reset", longint'(rd_en), 0);

        // R3 R4 R5: every pairing of corruption kinds in the two halves.
        for (int c0 = 0; c0 < 8; c0++) begin
            for (int c1 = 0; c1 < 8; c1++) begin
                logic [31:0] g0, g1;
                g0 = 32'(c0 * 5 + c1 + 1);
                g1 = (c0 == c1) ? g0 : 32'(c1 * 7 + c0 + 2);
                build_bank(0, g0, c0 + 3, 1'b0);
                build_bank(1, g1, c1 + 17, 1'b0);
                if (c0 != 0) mem[kind_off(c0)]     = mem[kind_off(c0)] ^ 8'h01;
                if (c1 != 0) mem[N + kind_off(c1)] = mem[N + kind_off(c1)] ^ 8'h01;
                run_check(c0 == 0, c1 == 0, g0, g1, kind_req(c0), kind_req(c1), 1'b0);
            end
        end

        // R6 R7: generation ordering, big-endian field and unsigned compare.
        for (int k = 0; k < 9; k++) begin
            build_bank(0, pg0[k], k, 1'b0);
            build_bank(1, pg1[k], k + 40, 1'b0);
            run_check(1'b1, 1'b1, pg0[k], pg1[k], "R6", "R6", 1'b0);
        end

        // R5: all-0xFF payload drives both sums through the modulus.
        build_bank(0, 32'd9, 0, 1'b1);
        build_bank(1, 32'd2, 0, 1'b1);
        run_check(1'b1, 1'b1, 32'd9, 32'd2, "R5", "R5", 1'b0);
        mem[N + N - 1] = 8'hFE;
        run_check(1'b1, 1'b0, 32'd9, 32'd2, "R5", "R5", 1'b0);

        // R10: start pulse during a scan is ignored.
        build_bank(0, 32'd1, 5, 1'b0);
        build_bank(1, 32'd4, 6, 1'b0);
        run_check(1'b1, 1'b1, 32'd1, 32'd4, "R10", "R10", 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule